// File: doc/BRIEF.md
# Debug-Port Instruction Decode Engine

This block turns a stream of received bytes from a serial debug physical layer into accesses on an internal memory bus. It latches each instruction byte in a held instruction register and collects the operand bytes that the instruction calls for: address, data, repeat count or key bytes. It then runs the access on a simple byte-wide bus master port. Every byte read on the bus, or from the block's own registers, goes back to the physical layer for transmission.

The block keeps a persistent 32-bit pointer. Direct accesses load it and indirect accesses use it, with an optional post-increment. It also holds a three-entry control/status register file. A repeat counter lets one held instruction run many times without its opcode being sent again. A key command sets an unlock flag, and bus traffic needs that flag.

The physical layer presents one byte per `rx_valid` pulse. It must space the bytes so that each one arrives while the engine waits for input. A byte that arrives during a bus access or a register update is dropped.

Top module: `dbg_instr_engine`

## Requirements
- R1: An instruction byte has its opcode in bits 7:5: 000 direct load, 001 indirect load, 010 direct store, 011 indirect store, 100 register load, 101 repeat, 110 register store, 111 key. It is kept in the instruction register until the next instruction byte replaces it.
- R2: Direct load/store takes 1 to 4 address bytes, least significant first, with the count set by bits 3:2 (00..11 = 1..4 bytes). These bytes become the pointer, and pointer bytes above the count are cleared. Byte i of the access goes to pointer+i, and the pointer is unchanged after the access.
- R3: Bits 1:0 set 1 to 4 data bytes per access (00..11 = 1..4), least significant first. Load data goes out on `tx_data` in address order, and store data bytes follow the address bytes on the receive side.
- R4: Indirect mode (bits 3:2) 00 accesses at the pointer and leaves it unchanged. Mode 01 accesses at the pointer and then advances it by the data byte count.
- R5: Indirect mode 10 loads or stores the bytes of the pointer itself, least significant first, with no bus request.
- R6: Indirect mode 11 does nothing: no bus request, no transmit byte, no operand consumed. The next received byte is decoded as an instruction.
- R7: Register load/store use bits 3:0 as the register address, and bit 4 must be 0. Registers 0 and 2 are 8-bit read/write. Register 1 reads back the unlock flag in bit 0 and ignores stores. Every other address reads 0x00 and ignores stores. Each register load returns exactly one byte.
- R8: Key takes 8 bytes, least significant first. It sets the unlock flag when they equal the 64-bit key parameter and clears the flag otherwise.
- R9: While the unlock flag is clear, loads from the bus return 0x00 bytes and stores make no bus request.
- R10: Repeat reads 1 to 4 count bytes, sized by bits 1:0, least significant first. The next instruction then runs N times from one opcode byte, or once when N is 0 or 1. Direct forms take fresh operand bytes on each run, and normal decoding resumes afterwards.
- R11: A bus request holds its address, write flag and write data steady until `bus_ready`, and moves exactly one byte per accepted cycle.
- R12: After reset no request or transmit byte is active, the unlock flag and registers 0 and 2 are zero, and the pointer is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | One-cycle pulse marking a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | One-cycle pulse marking a byte to transmit |
| tx_data | output | 8 | Byte to transmit |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 32 | Byte address of the access |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, valid with `bus_ready` |
| bus_ready | input | 1 | Completes the requested access this cycle |

## Verification
The riskiest cycle is the one where the last byte of a post-incrementing indirect access completes. In that same cycle the repeat counter decrements and the held opcode is dispatched again. The pointer advance and the re-dispatch must both land, or the next run reads the wrong address. The bench provokes this with a repeat count of 3 in front of a post-incrementing one-byte load while `bus_ready` toggles every cycle. It judges the result by the exact sequence of transmitted bytes against the bench memory model and by the pointer value read back afterwards. Two stores under one repeat check the other path, where re-dispatch has to collect fresh address and data bytes.

// File: rtl/dbg_eng_pkg.sv
package dbg_eng_pkg;

  localparam int PTR_W = 32;
  localparam int CNT_W = 32;

  typedef enum logic [2:0] {
    OP_LDS  = 3'b000,
    OP_LD   = 3'b001,
    OP_STS  = 3'b010,
    OP_ST   = 3'b011,
    OP_LDCS = 3'b100,
    OP_RPT  = 3'b101,
    OP_STCS = 3'b110,
    OP_KEY  = 3'b111
  } op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_ADDR, S_WDAT, S_ACC, S_CNT, S_KEY
  } st_e;

  localparam logic [1:0] PM_AT  = 2'b00;
  localparam logic [1:0] PM_INC = 2'b01;
  localparam logic [1:0] PM_REG = 2'b10;
  localparam logic [1:0] PM_RSV = 2'b11;

endpackage

// File: rtl/dbg_opcode_dec.sv
module dbg_opcode_dec
  import dbg_eng_pkg::*;
(
  input  logic [7:0] instr,
  output op_e        op,
  output logic [1:0] fld_a,
  output logic [1:0] dsz,
  output logic [4:0] cs_sel,
  output logic       is_load
);

  assign op      = op_e'(instr[7:5]);
  assign fld_a   = instr[3:2];
  assign dsz     = instr[1:0];
  assign cs_sel  = instr[4:0];
  assign is_load = (op == OP_LDS) || (op == OP_LD);

endmodule

// File: rtl/dbg_key_cmp.sv
module dbg_key_cmp #(
  parameter logic [63:0] KEY_VALUE = 64'h0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       shift_en,
  input  logic [7:0] byte_in,
  output logic       last_byte,
  output logic       match
);

  localparam int NBYTES = 8;
  localparam int IDX_W  = $clog2(NBYTES);

  logic [IDX_W-1:0]      idx_q, idx_d;
  logic [8*NBYTES-9:0]   kbuf_q, kbuf_d;

  always_comb begin
    idx_d  = idx_q;
    kbuf_d = kbuf_q;
    if (clr) begin
      idx_d = '0;
    end else if (shift_en) begin
      idx_d = idx_q + 1'b1;
      for (int g = 0; g < NBYTES - 1; g++) begin
        if (idx_q == IDX_W'(g)) kbuf_d[g*8 +: 8] = byte_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q  <= '0;
      kbuf_q <= '0;
    end else begin
      idx_q  <= idx_d;
      kbuf_q <= kbuf_d;
    end
  end

  assign last_byte = (idx_q == IDX_W'(NBYTES - 1));
  assign match     = ({byte_in, kbuf_q} == KEY_VALUE);

endmodule

// File: rtl/dbg_cs_regs.sv
module dbg_cs_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] sel,
  input  logic [7:0] wdata,
  input  logic       key_upd,
  input  logic       key_match,
  output logic [7:0] rd_data,
  output logic       key_ok
);

  logic [7:0] r0_q, r0_d, r2_q, r2_d;
  logic       ok_q, ok_d;

  always_comb begin
    r0_d = r0_q;
    r2_d = r2_q;
    ok_d = ok_q;
    if (wr_en && sel == 5'd0) r0_d = wdata;
    if (wr_en && sel == 5'd2) r2_d = wdata;
    if (key_upd) ok_d = key_match;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_q <= '0;
      r2_q <= '0;
      ok_q <= 1'b0;
    end else begin
      r0_q <= r0_d;
      r2_q <= r2_d;
      ok_q <= ok_d;
    end
  end

  always_comb begin
    case (sel)
      5'd0:    rd_data = r0_q;
      5'd1:    rd_data = {7'b0, ok_q};
      5'd2:    rd_data = r2_q;
      default: rd_data = 8'h00;
    endcase
  end

  assign key_ok = ok_q;

  AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !key_upd |=> $stable(key_ok)); // R8

endmodule

// File: rtl/dbg_instr_engine.sv
module dbg_instr_engine
  import dbg_eng_pkg::*;
#(
  parameter logic [63:0] KEY_VALUE = 64'hC3A5_9E71_0B4D_26F8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        bus_req,
  output logic        bus_we,
  output logic [31:0] bus_addr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  input  logic        bus_ready
);

  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  st_e              st_q, st_d;
  logic [7:0]       ir_q, ir_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] rpt_q, rpt_d;
  logic [1:0]       idx_q, idx_d;
  logic [7:0]       wb_q, wb_d;
  logic             txv_q, txv_d;
  logic [7:0]       txd_q, txd_d;

  op_e        op;
  logic [1:0] fld_a, dsz;
  logic [4:0] cs_sel;
  logic       is_load;
  logic       cs_wr, key_upd, key_match, key_ok, key_clr, key_shift, key_last;
  logic [7:0] cs_rd;
  logic       req_c, done, beat, ind, mode_reg;

  dbg_opcode_dec u_dec (
    .instr(ir_q), .op(op), .fld_a(fld_a), .dsz(dsz), .cs_sel(cs_sel), .is_load(is_load)
  );

  dbg_cs_regs u_cs (
    .clk(clk), .rst_n(rst_ns), .wr_en(cs_wr), .sel(cs_sel), .wdata(rx_data),
    .key_upd(key_upd), .key_match(key_match), .rd_data(cs_rd), .key_ok(key_ok)
  );

  dbg_key_cmp #(.KEY_VALUE(KEY_VALUE)) u_key (
    .clk(clk), .rst_n(rst_ns), .clr(key_clr), .shift_en(key_shift), .byte_in(rx_data),
    .last_byte(key_last), .match(key_match)
  );

  assign ind      = (op == OP_LD) || (op == OP_ST);
  assign mode_reg = ind && (fld_a == PM_REG);

  always_comb begin
    st_d = st_q;  ir_d = ir_q;  ptr_d = ptr_q;  rpt_d = rpt_q;
    idx_d = idx_q;  wb_d = wb_q;  txv_d = 1'b0;  txd_d = 8'h00;
    req_c = 1'b0;  done = 1'b0;  beat = 1'b0;
    cs_wr = 1'b0;  key_upd = 1'b0;  key_clr = 1'b0;  key_shift = 1'b0;
    case (st_q)
      S_IDLE: if (rx_valid) begin
        ir_d = rx_data;
        st_d = S_EXEC;
      end
      S_EXEC: begin
        idx_d = '0;
        case (op)
          OP_LDS, OP_STS: st_d = S_ADDR;
          OP_LD, OP_ST: begin
            if (fld_a == PM_RSV) done = 1'b1;
            else st_d = is_load ? S_ACC : S_WDAT;
          end
          OP_LDCS: begin
            txv_d = 1'b1;
            txd_d = cs_rd;
            done  = 1'b1;
          end
          OP_STCS: st_d = S_WDAT;
          OP_RPT: begin
            rpt_d = '0;
            st_d  = S_CNT;
          end
          default: begin
            key_clr = 1'b1;
            st_d    = S_KEY;
          end
        endcase
      end
      S_ADDR: if (rx_valid) begin
        if (idx_q == 2'd0) ptr_d = {{(PTR_W-8){1'b0}}, rx_data};
        else ptr_d[{idx_q, 3'b000} +: 8] = rx_data;
        if (idx_q == fld_a) begin
          idx_d = '0;
          st_d  = is_load ? S_ACC : S_WDAT;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      S_WDAT: if (rx_valid) begin
        wb_d = rx_data;
        if (op == OP_STCS) begin
          cs_wr = 1'b1;
          done  = 1'b1;
        end else begin
          st_d = S_ACC;
        end
      end
      S_ACC: begin
        if (mode_reg) begin
          beat = 1'b1;
          if (is_load) begin
            txv_d = 1'b1;
            txd_d = ptr_q[{idx_q, 3'b000} +: 8];
          end else begin
            ptr_d[{idx_q, 3'b000} +: 8] = wb_q;
          end
        end else if (!key_ok) begin
          beat  = 1'b1;
          txv_d = is_load;
        end else begin
          req_c = 1'b1;
          beat  = bus_ready;
          if (is_load && bus_ready) begin
            txv_d = 1'b1;
            txd_d = bus_rdata;
          end
        end
        if (beat) begin
          if (idx_q == dsz) begin
            idx_d = '0;
            if (ind && fld_a == PM_INC) ptr_d = ptr_q + PTR_W'(dsz) + PTR_W'(1);
            done = 1'b1;
          end else begin
            idx_d = idx_q + 2'd1;
            st_d  = is_load ? S_ACC : S_WDAT;
          end
        end
      end
      S_CNT: if (rx_valid) begin
        rpt_d[{idx_q, 3'b000} +: 8] = rx_data;
        if (idx_q == dsz) begin
          idx_d = '0;
          st_d  = S_IDLE;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      S_KEY: if (rx_valid) begin
        key_shift = 1'b1;
        if (key_last) begin
          key_upd = 1'b1;
          st_d    = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
    if (done) begin
      if (rpt_q > CNT_W'(1)) begin
        rpt_d = rpt_q - CNT_W'(1);
        st_d  = S_EXEC;
      end else begin
        rpt_d = '0;
        st_d  = S_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      st_q  <= S_IDLE;
      ir_q  <= '0;
      ptr_q <= '0;
      rpt_q <= '0;
      idx_q <= '0;
      wb_q  <= '0;
      txv_q <= 1'b0;
      txd_q <= '0;
    end else begin
      st_q  <= st_d;
      ir_q  <= ir_d;
      ptr_q <= ptr_d;
      rpt_q <= rpt_d;
      idx_q <= idx_d;
      wb_q  <= wb_d;
      txv_q <= txv_d;
      txd_q <= txd_d;
    end
  end

  assign tx_valid  = txv_q;
  assign tx_data   = txd_q;
  assign bus_req   = req_c;
  assign bus_we    = !is_load;
  assign bus_addr  = ptr_q + PTR_W'(idx_q);
  assign bus_wdata = wb_q;

  AST_BUS_KEYED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> key_ok); // R9

  AST_BUS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ready) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)
                                 && $stable(bus_wdata))); // R11

  AST_TX_FROM_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> (op == OP_LDS || op == OP_LD || op == OP_LDCS)); // R3

  AST_RPT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != S_CNT) |=> (rpt_q == $past(rpt_q) || rpt_q == $past(rpt_q) - CNT_W'(1)
                         || rpt_q == '0)); // R10

endmodule

// File: tb/dbg_instr_engine_tb.sv
module dbg_instr_engine_tb;

  localparam logic [63:0] KEY = 64'hC3A5_9E71_0B4D_26F8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_valid;
  logic [7:0]  rx_data;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        bus_req, bus_we, bus_ready;
  logic [31:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata;

  always #5 clk = ~clk;

  dbg_instr_engine #(.KEY_VALUE(KEY)) u_dut (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .tx_valid(tx_valid), .tx_data(tx_data), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready)
  );

  logic [7:0] mem [256];
  logic       stall_en;
  logic       rdy_t;
  int         n_acc, n_wr;
  int         checks, errors;
  logic [7:0] txq [$];
  logic [7:0] expq [$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_t <= 1'b0;
    else        rdy_t <= stall_en ? ~rdy_t : 1'b1;
  end
  assign bus_ready = rdy_t;
  assign bus_rdata = mem[bus_addr[7:0]];

  always @(posedge clk) begin
    if (rst_n && bus_req && bus_ready) begin
      n_acc <= n_acc + 1;
      if (bus_we) begin
        mem[bus_addr[7:0]] <= bus_wdata;
        n_wr <= n_wr + 1;
      end
    end
  end

  always @(negedge clk) if (rst_n && tx_valid) txq.push_back(tx_data);

  function automatic logic [7:0] initv(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_tx(string tag);
    checks++;
    if (txq.size() != expq.size()) begin
      errors++;
      $display("FAIL %s: actual %0d tx bytes expected %0d", tag, txq.size(), expq.size());
    end else begin
      foreach (expq[k]) begin
        if (txq[k] !== expq[k]) begin
          errors++;
          $display("FAIL %s: byte %0d actual %0h expected %0h", tag, k, txq[k], expq[k]);
        end
      end
    end
    txq.delete();
    expq.delete();
  endtask

  task automatic send(logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic send_le(logic [31:0] v, int n);
    for (int i = 0; i < n; i++) send(v[8*i +: 8]);
  endtask

  task automatic settle();
    repeat (16) @(negedge clk);
  endtask

  task automatic read_ptr(output logic [31:0] p);
    send(8'h2B);
    settle();
    p = '0;
    for (int i = 0; i < 4; i++) if (i < txq.size()) p[8*i +: 8] = txq[i];
    checks++;
    if (txq.size() != 4) begin
      errors++;
      $display("FAIL R5: actual %0d pointer bytes expected 4", txq.size());
    end
    txq.delete();
  endtask

  task automatic write_ptr(logic [31:0] v);
    send(8'h6B);
    send_le(v, 4);
    settle();
  endtask

  task automatic send_key(logic [63:0] k);
    send(8'hE0);
    for (int i = 0; i < 8; i++) send(k[8*i +: 8]);
    settle();
  endtask

  task automatic ldcs(logic [3:0] r, logic [7:0] exp, string tag);
    send(8'h80 | 8'(r));
    settle();
    expq.push_back(exp);
    expect_tx(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] p;
    logic [7:0]  snap;
    int          acc0, wr0;
    checks = 0; errors = 0; n_acc = 0; n_wr = 0;
    rx_valid = 1'b0; rx_data = '0; stall_en = 1'b0;
    for (int i = 0; i < 256; i++) mem[i] = initv(i);
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 reset state
    check("R12 tx_valid", 32'(tx_valid), 0);
    check("R12 bus_req", 32'(bus_req), 0);
    ldcs(4'd1, 8'h00, "R12 R7 unlock flag");
    ldcs(4'd0, 8'h00, "R12 reg0");
    ldcs(4'd2, 8'h00, "R12 reg2");
    read_ptr(p);
    check("R12 pointer", p, 0);

    // R9 locked: loads return zero, stores make no request
    acc0 = n_acc;
    send(8'h00); send(8'h10); settle();
    expq.push_back(8'h00);
    expect_tx("R9 locked load");
    send(8'h40); send(8'h11); send(8'h99); settle();
    check("R9 locked store mem", 32'(mem[8'h11]), 32'(initv(8'h11)));
    check("R9 no bus request", n_acc, acc0);

    // R8 key
    send_key(KEY ^ 64'h1);
    ldcs(4'd1, 8'h00, "R8 wrong key");
    send_key(KEY);
    ldcs(4'd1, 8'h01, "R8 right key");

    // R2 R3 direct loads over every address and data size
    for (int as = 0; as < 4; as++) begin
      for (int ds = 0; ds < 4; ds++) begin
        int a;
        a = 32 + as * 16 + ds * 4;
        stall_en = 1'(ds);
        send(8'((as << 2) | ds));
        send_le(32'(a), as + 1);
        settle();
        for (int i = 0; i <= ds; i++) expq.push_back(initv(a + i));
        expect_tx("R2 R3 direct load");
        read_ptr(p);
        check("R2 pointer after direct", p, 32'(a));
      end
    end

    // R2 upper pointer bytes cleared
    write_ptr(32'hFFFF_FFFF);
    send(8'h00); send(8'h33); settle();
    expq.push_back(initv(8'h33));
    expect_tx("R2 short address load");
    read_ptr(p);
    check("R2 upper bytes cleared", p, 32'h33);

    // R3 R11 direct stores
    for (int ds = 0; ds < 4; ds++) begin
      int a;
      a = 144 + ds * 8;
      stall_en = 1'(ds);
      wr0 = n_wr;
      send(8'h44 | 8'(ds));
      send_le(32'(a), 2);
      for (int i = 0; i <= ds; i++) send(8'(160 + ds * 16 + i));
      settle();
      for (int i = 0; i <= ds; i++)
        check("R3 store byte", 32'(mem[a + i]), 32'(160 + ds * 16 + i));
      check("R11 one write per byte", n_wr - wr0, ds + 1);
    end

    // R4 R5 indirect
    stall_en = 1'b1;
    write_ptr(32'h40);
    read_ptr(p);
    check("R5 pointer write", p, 32'h40);
    send(8'h21); settle();
    expq.push_back(initv(8'h40)); expq.push_back(initv(8'h41));
    expect_tx("R4 load at pointer");
    read_ptr(p);
    check("R4 pointer unchanged", p, 32'h40);
    send(8'h26); settle();
    for (int i = 0; i < 3; i++) expq.push_back(initv(8'h40 + i));
    expect_tx("R4 post-increment load");
    read_ptr(p);
    check("R4 pointer advanced", p, 32'h43);
    send(8'h64); send(8'h5E); settle();
    check("R4 post-increment store", 32'(mem[8'h43]), 32'h5E);
    read_ptr(p);
    check("R4 pointer after store", p, 32'h44);

    // R6 reserved mode
    acc0 = n_acc;
    send(8'h2F); settle();
    check("R6 no tx", txq.size(), 0);
    check("R6 no bus", n_acc, acc0);
    ldcs(4'd1, 8'h01, "R6 next byte is instruction");
    send(8'h6C);
    ldcs(4'd1, 8'h01, "R6 store operand not consumed");
    read_ptr(p);
    check("R6 pointer untouched", p, 32'h44);

    // R7 control/status registers
    send(8'hC0); send(8'hA5);
    send(8'hC2); send(8'h3C);
    send(8'hC1); send(8'h00);
    send(8'hC5); send(8'hFF);
    settle();
    ldcs(4'd0, 8'hA5, "R7 reg0");
    ldcs(4'd2, 8'h3C, "R7 reg2");
    ldcs(4'd1, 8'h01, "R7 reg1 ignores store");
    ldcs(4'd5, 8'h00, "R7 reserved 5");
    ldcs(4'd15, 8'h00, "R7 reserved 15");
    send(8'h92); settle();
    expq.push_back(8'h00);
    expect_tx("R7 bit4 set is reserved");

    // R10 R1 repeat of a held post-increment load under stalls
    write_ptr(32'h80);
    send(8'hA0); send(8'h03);
    send(8'h24); settle();
    for (int i = 0; i < 3; i++) expq.push_back(initv(8'h80 + i));
    expect_tx("R10 R1 repeated load");
    read_ptr(p);
    check("R10 pointer after repeat", p, 32'h83);

    // R10 repeated direct store takes fresh operands
    send(8'hA1); send(8'h02); send(8'h00);
    send(8'h40); send(8'hB0); send(8'h71); send(8'hB1); send(8'h72);
    settle();
    check("R10 first store", 32'(mem[8'hB0]), 32'h71);
    check("R10 second store", 32'(mem[8'hB1]), 32'h72);
    ldcs(4'd1, 8'h01, "R10 decoding resumes");

    send(8'hA0); send(8'h00);
    ldcs(4'd2, 8'h3C, "R10 count zero runs once");
    send(8'hA0); send(8'h04);
    send(8'h82); settle();
    for (int i = 0; i < 4; i++) expq.push_back(8'h3C);
    expect_tx("R10 R1 repeated register load");

    // R9 relock
    send_key(64'h0);
    ldcs(4'd1, 8'h00, "R8 relock");
    acc0 = n_acc;
    snap = mem[8'h84];
    send(8'h00); send(8'h80); settle();
    expq.push_back(8'h00);
    expect_tx("R9 relocked load");
    send(8'h40); send(8'h84); send(8'h00); settle();
    check("R9 relocked store", 32'(mem[8'h84]), 32'(snap));
    check("R9 relocked no bus", n_acc, acc0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule